// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This peripheral holds four independent down counters and one shared interrupt controller. They sit behind a simple register bus with address, write data, read data, a write strobe and a read strobe. Each counter advances only on cycles where the timer tick input is high, after a per-channel prescaler divides those ticks. A channel can run free, reload from a separate background register at each wrap, or expire once and park. It can count in 16 or 32 bits. Software reads the inverse of a free-running counter to get an up-counting timestamp.

A channel underflow sets a raw status bit for that channel. The raw bits are masked, read back and cleared through shared registers at the bottom of the map. The single interrupt output is high while any unmasked raw bit is set. The counters are typically used in pairs: one free-running channel serves as the time base, and a second channel runs periodic or one-shot for event timing.

Top module: `quad_down_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is 0.
- R2: A read presents its data on `bus_rdata` one clock after the cycle in which `bus_re` is high, and `bus_rdata` holds while `bus_re` is low. The load and background registers read back the full 32-bit value last written. The control register reads back the low 8 bits of its last write.
- R3: Channel n's registers sit at byte address 0x10 + 0x10*n, with load at +0x0, current value at +0x4, control at +0x8 and background at +0xC. A register is decoded only when address bits 1:0 are 0.
- R4: Writing the load register sets the counter to the written value on the next edge. When control bit 1 is 0 (16-bit mode), only bits 15:0 are kept and the upper 16 bits of the current value read as 0.
- R5: Control bits 3:2 select the prescaler: 00 gives one count step per tick, 01 one step per 16 ticks and 10 or 11 one step per 256 ticks. The first step comes on the 16th or 256th tick after the channel is enabled, because the prescaler restarts whenever control bit 7 is 0.
- R6: While control bit 7 is 1, each step lowers a non-zero counter by 1. While bit 7 is 0 the counter holds its value, so writing 0 to the control register stops the channel.
- R7: In free-running mode (bit 6 = 0, bit 0 = 0), a step taken at value 0 reloads the all-ones value for the width (0xFFFF or 0xFFFFFFFF) and sets raw bit n.
- R8: In periodic mode (bit 6 = 1, bit 0 = 0), a step taken at value 0 reloads the background value and sets raw bit n. Writing the background register does not change a running counter.
- R9: In one-shot mode (bit 0 = 1, regardless of bit 6), a step taken at value 0 sets raw bit n once. The counter then stays at 0 with no further underflow until the load or control register of that channel is written.
- R10: Offset 0x00 is the read/write interrupt mask, 0x04 the raw status and 0x08 the masked status (raw AND mask), all with bit n for channel n. `irq` is the OR of the masked bits.
- R11: Writing 1 to bit n at offset 0x0C clears raw bit n on the next edge. If channel n underflows in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Timer tick, counters advance only when high |
| irq | output | 1 | OR of the masked interrupt bits |

## Verification
Register writes and tick-driven count steps take effect on the same edge that samples them. Raw status and `irq` change on the edge of the underflow step, while read data appears one edge after the read strobe. The bench drives all strobes and ticks between edges and pushes each expected read value into a queue. A monitor pops that queue at the falling edge after each sampled read strobe, and `irq` is sampled directly at that same falling edge. Tick pulses are counted one by one so that every expected counter value, including the prescaler boundaries and a clear that coincides with an underflow, follows from the requirements.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    localparam int unsigned PRE_W = 8;

    localparam logic [1:0] SUB_MASK  = 2'd0;
    localparam logic [1:0] SUB_RAW   = 2'd1;
    localparam logic [1:0] SUB_MIS   = 2'd2;
    localparam logic [1:0] SUB_CLR   = 2'd3;

    localparam logic [1:0] SUB_LOAD  = 2'd0;
    localparam logic [1:0] SUB_VALUE = 2'd1;
    localparam logic [1:0] SUB_CTRL  = 2'd2;
    localparam logic [1:0] SUB_BG    = 2'd3;

    // control byte, msb first
    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] spare;
        logic [1:0] psel;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } wrap_mode_e;

    function automatic wrap_mode_e mode_of(ctrl_t c);
        if (c.oneshot)       return MODE_ONESHOT;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    // prescaler steps when the low bits of its counter are all ones
    function automatic logic [PRE_W-1:0] pre_limit(logic [1:0] sel);
        case (sel)
            2'b00:   return '0;
            2'b01:   return PRE_W'(8'h0F);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler
    import qdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic [1:0] psel,
    output logic       step
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = pre_limit(psel);
    assign step = enable && tick && ((pre_q & lim) == lim);

    always_ff @(posedge clk) begin
        if (rst || !enable)
            pre_q <= '0;
        else if (tick)
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_load,
    input  logic          wr_ctrl,
    input  logic          wr_bg,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] load_rd,
    output logic [DW-1:0] value_rd,
    output ctrl_t         ctrl_rd,
    output logic [DW-1:0] bg_rd,
    output logic          underflow
);

    localparam int unsigned HALF_W = DW / 2;

    ctrl_t         ctrl_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] load_q;
    logic [DW-1:0] bg_q;
    logic          done_q;

    logic [DW-1:0] wmask;
    logic [DW-1:0] cnt_m;
    logic          step;
    logic          active_step;
    wrap_mode_e    mode;

    qdt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl_q.en),
        .tick   (tick),
        .psel   (ctrl_q.psel),
        .step   (step)
    );

    assign wmask       = ctrl_q.wide ? {DW{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign cnt_m       = cnt_q & wmask;
    assign mode        = mode_of(ctrl_q);
    assign active_step = step && !done_q;
    assign underflow   = active_step && !wr_load && (cnt_m == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            load_q <= '0;
            bg_q   <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_load) begin
                load_q <= wdata;
                cnt_q  <= wdata & wmask;
                done_q <= 1'b0;
            end else if (active_step) begin
                if (cnt_m != '0) begin
                    cnt_q <= (cnt_m - 1'b1) & wmask;
                end else begin
                    case (mode)
                        MODE_FREE:     cnt_q <= wmask;
                        MODE_PERIODIC: cnt_q <= bg_q & wmask;
                        default: begin
                            cnt_q  <= '0;
                            done_q <= 1'b1;
                        end
                    endcase
                end
            end
            if (wr_bg)
                bg_q <= wdata;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[7:0]);
                done_q <= 1'b0;
            end
        end
    end

    assign load_rd  = load_q;
    assign value_rd = cnt_m;
    assign ctrl_rd  = ctrl_q;
    assign bg_rd    = bg_q;

    // R6: a step lowers a non-zero counter by one
    a_r6_step_decrements: assert property (@(posedge clk) disable iff (rst)
        (active_step && !wr_load && !wr_ctrl && cnt_m != '0) |=> (value_rd == $past(cnt_m) - 1'b1));

    // R6: a disabled channel holds its value
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_load && !wr_ctrl) |=> $stable(value_rd));

    // R7: free-running wrap lands on all ones for the width
    a_r7_free_wrap: assert property (@(posedge clk) disable iff (rst)
        (underflow && mode == MODE_FREE && !wr_ctrl) |=> (value_rd == $past(wmask)));

    // R8: periodic wrap lands on the background value
    a_r8_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (underflow && mode == MODE_PERIODIC && !wr_ctrl && !wr_bg) |=> (value_rd == $past(bg_q & wmask)));

    // R9: an expired one-shot channel stays parked at zero
    a_r9_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
        (done_q && !wr_load && !wr_ctrl) |=> (value_rd == '0 && !underflow));

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mask,
    input  logic            wr_clr,
    input  logic [N_CH-1:0] wbits,
    input  logic [N_CH-1:0] uf,
    output logic [N_CH-1:0] mask_q,
    output logic [N_CH-1:0] raw_q,
    output logic [N_CH-1:0] mis,
    output logic            irq
);

    logic [N_CH-1:0] clr_bits;

    assign clr_bits = wr_clr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_mask)
                mask_q <= wbits;
            raw_q <= (raw_q & ~clr_bits) | uf;
        end
    end

    assign mis = raw_q & mask_q;
    assign irq = |mis;

    // R11: a new underflow survives a same-cycle clear
    a_r11_underflow_wins: assert property (@(posedge clk) disable iff (rst)
        (uf != '0) |=> ((raw_q & $past(uf)) == $past(uf)));

    // R11: a clear without a competing underflow takes effect
    a_r11_clear_takes: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & ~uf) != '0) |=> ((raw_q & $past(clr_bits & ~uf)) == '0));

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tick_en,
    output logic              irq
);

    localparam int unsigned REG_W = ADDR_W - 4;

    logic [REG_W-1:0] region;
    logic [1:0]       sub;
    logic             aligned;
    logic             shared_we;

    logic [DW-1:0]    ch_load  [N_CH];
    logic [DW-1:0]    ch_value [N_CH];
    ctrl_t            ch_ctrl  [N_CH];
    logic [DW-1:0]    ch_bg    [N_CH];
    logic [N_CH-1:0]  uf_vec;

    logic [N_CH-1:0]  mask_q;
    logic [N_CH-1:0]  raw_q;
    logic [N_CH-1:0]  mis;
    logic [DW-1:0]    rd_next;

    assign region    = bus_addr[ADDR_W-1:4];
    assign sub       = bus_addr[3:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign shared_we = bus_we && aligned && (region == '0);

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_ch
            logic sel;
            assign sel = bus_we && aligned && (region == REG_W'(g + 1));

            qdt_channel #(.DW(DW)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick_en),
                .wr_load   (sel && sub == SUB_LOAD),
                .wr_ctrl   (sel && sub == SUB_CTRL),
                .wr_bg     (sel && sub == SUB_BG),
                .wdata     (bus_wdata),
                .load_rd   (ch_load[g]),
                .value_rd  (ch_value[g]),
                .ctrl_rd   (ch_ctrl[g]),
                .bg_rd     (ch_bg[g]),
                .underflow (uf_vec[g])
            );
        end
    endgenerate

    qdt_irq #(.N_CH(N_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (shared_we && sub == SUB_MASK),
        .wr_clr  (shared_we && sub == SUB_CLR),
        .wbits   (bus_wdata[N_CH-1:0]),
        .uf      (uf_vec),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .mis     (mis),
        .irq     (irq)
    );

    always_comb begin
        rd_next = '0;
        if (aligned) begin
            if (region == '0) begin
                case (sub)
                    SUB_MASK: rd_next = {{(DW-N_CH){1'b0}}, mask_q};
                    SUB_RAW:  rd_next = {{(DW-N_CH){1'b0}}, raw_q};
                    SUB_MIS:  rd_next = {{(DW-N_CH){1'b0}}, mis};
                    default:  rd_next = '0;
                endcase
            end
            for (int i = 0; i < N_CH; i++) begin
                if (region == REG_W'(i + 1)) begin
                    case (sub)
                        SUB_LOAD:  rd_next = ch_load[i];
                        SUB_VALUE: rd_next = ch_value[i];
                        SUB_CTRL:  rd_next = {{(DW-8){1'b0}}, ch_ctrl[i]};
                        default:   rd_next = ch_bg[i];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_next;
    end

    // R2: read data only moves on a read strobe
    a_r2_read_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/quad_down_timer_tb.sv
module quad_down_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    quad_down_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  pend   = 1'b0;
    bit    ended  = 1'b0;

    always @(posedge clk) pend <= bus_re;

    // monitor: read data is due one edge after the strobe
    always @(negedge clk) begin
        item_t e;
        if (pend) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected read data act %h exp none", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %h act %h exp %h", e.tag, e.addr, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        sbq.push_back('{addr: a, exp: exp, tag: tag});
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq act %b exp %b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act hung exp done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h14, 32'h0, "R1");
        rd(8'h18, 32'h0, "R1");
        rd(8'h4C, 32'h0, "R1");

        // R2 readback, R4 16-bit masking of the live value
        wr(8'h20, 32'h1234_5678);
        rd(8'h20, 32'h1234_5678, "R2");
        rd(8'h24, 32'h0000_5678, "R4");
        wr(8'h2C, 32'hAAAA_5555);
        rd(8'h2C, 32'hAAAA_5555, "R2");
        wr(8'h28, 32'h0000_01C3);
        rd(8'h28, 32'h0000_00C3, "R2");
        wr(8'h28, 32'h0);
        rd(8'h22, 32'h0, "R3");

        // R6 counting and stopping on channel 0
        wr(8'h10, 32'd10);
        wr(8'h18, 32'h82);
        ticks(3);
        rd(8'h14, 32'd7, "R6");
        wr(8'h18, 32'h02);
        ticks(3);
        rd(8'h14, 32'd7, "R6");

        // R7 free-running 32-bit wrap
        wr(8'h10, 32'd1);
        wr(8'h18, 32'h82);
        ticks(1);
        rd(8'h14, 32'd0, "R7");
        rd(8'h04, 32'h0, "R7");
        ticks(1);
        rd(8'h14, 32'hFFFF_FFFF, "R7");
        rd(8'h04, 32'h1, "R7");

        // R11 clear colliding with underflow, then plain clear
        wr(8'h10, 32'd0);
        wr_tick(8'h0C, 32'h1);
        rd(8'h04, 32'h1, "R11");
        rd(8'h14, 32'hFFFF_FFFF, "R11");
        wr(8'h0C, 32'h1);
        rd(8'h04, 32'h0, "R11");
        wr(8'h18, 32'h0);

        // R4 and R7 in 16-bit mode on channel 2
        wr(8'h38, 32'h80);
        wr(8'h30, 32'hFFFF_0001);
        rd(8'h34, 32'h1, "R4");
        rd(8'h30, 32'hFFFF_0001, "R2");
        ticks(2);
        rd(8'h34, 32'h0000_FFFF, "R7");
        rd(8'h04, 32'h4, "R7");
        wr(8'h38, 32'h0);

        // R10 masking and irq
        rd(8'h08, 32'h0, "R10");
        chk_irq(1'b0, "R10");
        wr(8'h00, 32'h4);
        rd(8'h08, 32'h4, "R10");
        chk_irq(1'b1, "R10");
        rd(8'h00, 32'h4, "R10");
        wr(8'h00, 32'h1);
        rd(8'h08, 32'h0, "R10");
        chk_irq(1'b0, "R10");
        wr(8'h0C, 32'h4);
        rd(8'h04, 32'h0, "R11");
        wr(8'h00, 32'hF);

        // R8 periodic reload on channel 3 (R3 map at 0x40)
        wr(8'h4C, 32'd2);
        wr(8'h40, 32'd1);
        wr(8'h48, 32'hC2);
        ticks(1);
        wr(8'h4C, 32'd5);
        rd(8'h44, 32'd0, "R8");
        rd(8'h04, 32'h0, "R8");
        ticks(1);
        rd(8'h44, 32'd5, "R8");
        rd(8'h04, 32'h8, "R8");
        chk_irq(1'b1, "R8");
        ticks(1);
        rd(8'h44, 32'd4, "R3");
        wr(8'h48, 32'h0);
        wr(8'h0C, 32'h8);
        chk_irq(1'b0, "R11");

        // R9 one-shot on channel 1
        wr(8'h20, 32'd1);
        wr(8'h28, 32'hC3);
        ticks(2);
        rd(8'h04, 32'h2, "R9");
        chk_irq(1'b1, "R9");
        wr(8'h0C, 32'h2);
        ticks(3);
        rd(8'h24, 32'd0, "R9");
        rd(8'h04, 32'h0, "R9");
        wr(8'h20, 32'd0);
        ticks(1);
        rd(8'h04, 32'h2, "R9");
        wr(8'h28, 32'h0);
        wr(8'h0C, 32'h2);

        // R5 prescaler on channel 0
        wr(8'h10, 32'd100);
        wr(8'h18, 32'h86);
        ticks(15);
        rd(8'h14, 32'd100, "R5");
        ticks(1);
        rd(8'h14, 32'd99, "R5");
        ticks(16);
        rd(8'h14, 32'd98, "R5");
        ticks(5);
        wr(8'h18, 32'h0);
        wr(8'h18, 32'h8A);
        ticks(255);
        rd(8'h14, 32'd98, "R5");
        ticks(1);
        rd(8'h14, 32'd97, "R5");
        wr(8'h18, 32'h0);

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 pending reads act %0d exp 0", sbq.size());
        end
        finish_run();
    end

endmodule